// File: doc/BRIEF.md
# Instruction Repeat and Loop Counter Unit

This unit sits beside the fetch stage of a DSP-style core. When decode signals a repeat request, the unit latches a count and re-issues the next instruction word. That word runs the count plus one times in total. While executions remain, the unit holds the program counter. It raises a completion strobe on the last execution and becomes idle on the following clock. The count can come from three places: an 8-bit immediate field (zero-extended), a full data-register value, or a memory word that was fetched through a pointer.

Two loop-counter registers sit next to the repeat logic. Software fills either one in two ways. A short-immediate load writes an 8-bit value, zero-extended. A control-register transfer, such as a pop or a register move, writes a full 16-bit word. Both counters are always visible on a packed output. Decode, memory access and branching are handled elsewhere.

Top module: `rep_loop_unit`

## Requirements
- R1: After reset, rep_exec, pc_hold and rep_done are low and every loop counter reads zero.
- R2: A request accepted while idle with count n makes rep_exec high for exactly n+1 consecutive cycles, starting the cycle after acceptance.
- R3: rpt_src selects the count. Code 0 uses rpt_imm zero-extended to 16 bits. Code 1 uses rpt_reg. Code 2 uses rpt_mem. Code 3 behaves like code 0.
- R4: pc_hold is high in every execution cycle except the last, and low outside a repeat.
- R5: rep_done is high only in the final execution cycle, and rep_exec is low on the next cycle.
- R6: A count of zero gives a single execution cycle in which rep_done is high and pc_hold is low.
- R7: A request that arrives while rep_exec is high, including the final cycle, is dropped and does not change the remaining run.
- R8: lc_ld loads the counter chosen by lc_sel with lc_imm zero-extended on the next clock. The other counter is unchanged.
- R9: cr_wr writes the full cr_wdata into the counter chosen by cr_sel. Counter i appears at lc_vals bits [16*i+15:16*i].
- R10: If lc_ld and cr_wr target the same counter in one cycle, the lc_ld value wins. If they target different counters, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_req | input | 1 | Repeat request strobe from decode |
| rpt_src | input | 2 | Count source code (see R3) |
| rpt_imm | input | 8 | Immediate count field |
| rpt_reg | input | 16 | Data register value |
| rpt_mem | input | 16 | Memory word read through a pointer |
| lc_ld | input | 1 | Short-immediate loop counter load |
| lc_sel | input | 1 | Counter chosen by lc_ld |
| lc_imm | input | 8 | Short immediate for lc_ld |
| cr_wr | input | 1 | Control-register write to a loop counter |
| cr_sel | input | 1 | Counter chosen by cr_wr |
| cr_wdata | input | 16 | Control-register write data |
| rep_exec | output | 1 | One strobe per execution of the repeated word |
| pc_hold | output | 1 | Program counter stall |
| rep_done | output | 1 | Final execution of the repeat |
| lc_vals | output | 32 | Packed loop counter values |

## Verification
The properties assume that every input is a known value once reset is released. They also assume decode is free to raise a request in any cycle, including while a repeat runs. The properties therefore express the dropping of such requests rather than forbid them. The stimulus drives every input on the falling edge and holds it for a whole cycle. Random phases assert requests, loads and writes independently, often in the same cycle. Register and memory counts stay small so that runs stay short. Directed cases cover the largest immediate and a register count above 8 bits.

// File: rtl/rl_pkg.sv
package rl_pkg;
    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_REG = 2'd1,
        SRC_MEM = 2'd2,
        SRC_ALT = 2'd3
    } rpt_src_e;
endpackage

// File: rtl/rl_cnt_mux.sv
module rl_cnt_mux #(
    parameter int CNT_W  = 16,
    parameter int SIMM_W = 8
) (
    input  logic [1:0]        src,
    input  logic [SIMM_W-1:0] imm,
    input  logic [CNT_W-1:0]  reg_val,
    input  logic [CNT_W-1:0]  mem_val,
    output logic [CNT_W-1:0]  cnt
);
    import rl_pkg::*;

    rpt_src_e sel;

    always_comb begin
        sel = rpt_src_e'(src);
        unique case (sel)
            SRC_REG: cnt = reg_val;
            SRC_MEM: cnt = mem_val;
            default: cnt = CNT_W'(imm);
        endcase
    end
endmodule

// File: rtl/rl_rep_ctrl.sv
module rl_rep_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             exec,
    output logic             hold,
    output logic             done
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } rep_st_t;

    rep_st_t st_d, st_q;
    logic    last;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (req) begin
                st_d.active = 1'b1;
                st_d.cnt    = cnt_in;
            end
        end else if (st_q.cnt == '0) begin
            st_d.active = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last = st_q.active && (st_q.cnt == '0);
    assign exec = st_q.active;
    assign done = last;
    assign hold = st_q.active && !last;
endmodule

// File: rtl/rl_loop_bank.sv
module rl_loop_bank #(
    parameter int CNT_W  = 16,
    parameter int SIMM_W = 8,
    parameter int NUM_LC = 2,
    localparam int SEL_W = (NUM_LC > 1) ? $clog2(NUM_LC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [SEL_W-1:0]        ld_sel,
    input  logic [SIMM_W-1:0]       ld_imm,
    input  logic                    wr,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [CNT_W-1:0]        wr_data,
    output logic [NUM_LC*CNT_W-1:0] vals
);
    logic [CNT_W-1:0] lc_d [NUM_LC];
    logic [CNT_W-1:0] lc_q [NUM_LC];

    always_comb begin
        for (int i = 0; i < NUM_LC; i++) begin
            lc_d[i] = lc_q[i];
            if (wr && (wr_sel == SEL_W'(i))) lc_d[i] = wr_data;
            if (ld && (ld_sel == SEL_W'(i))) lc_d[i] = CNT_W'(ld_imm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LC; i++) lc_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_LC; i++) lc_q[i] <= lc_d[i];
        end
    end

    for (genvar g = 0; g < NUM_LC; g++) begin : g_out
        assign vals[g*CNT_W +: CNT_W] = lc_q[g];
    end
endmodule

// File: rtl/rep_loop_unit.sv
module rep_loop_unit #(
    parameter int CNT_W  = 16,
    parameter int SIMM_W = 8,
    parameter int NUM_LC = 2,
    localparam int SEL_W = (NUM_LC > 1) ? $clog2(NUM_LC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rpt_req,
    input  logic [1:0]              rpt_src,
    input  logic [SIMM_W-1:0]       rpt_imm,
    input  logic [CNT_W-1:0]        rpt_reg,
    input  logic [CNT_W-1:0]        rpt_mem,
    input  logic                    lc_ld,
    input  logic [SEL_W-1:0]        lc_sel,
    input  logic [SIMM_W-1:0]       lc_imm,
    input  logic                    cr_wr,
    input  logic [SEL_W-1:0]        cr_sel,
    input  logic [CNT_W-1:0]        cr_wdata,
    output logic                    rep_exec,
    output logic                    pc_hold,
    output logic                    rep_done,
    output logic [NUM_LC*CNT_W-1:0] lc_vals
);
    logic [CNT_W-1:0] sel_cnt;

    rl_cnt_mux #(.CNT_W(CNT_W), .SIMM_W(SIMM_W)) u_mux (
        .src     (rpt_src),
        .imm     (rpt_imm),
        .reg_val (rpt_reg),
        .mem_val (rpt_mem),
        .cnt     (sel_cnt)
    );

    rl_rep_ctrl #(.CNT_W(CNT_W)) u_rep (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rpt_req),
        .cnt_in (sel_cnt),
        .exec   (rep_exec),
        .hold   (pc_hold),
        .done   (rep_done)
    );

    rl_loop_bank #(.CNT_W(CNT_W), .SIMM_W(SIMM_W), .NUM_LC(NUM_LC)) u_lc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (lc_ld),
        .ld_sel  (lc_sel),
        .ld_imm  (lc_imm),
        .wr      (cr_wr),
        .wr_sel  (cr_sel),
        .wr_data (cr_wdata),
        .vals    (lc_vals)
    );
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int CNT_W  = 16,
    parameter int SIMM_W = 8,
    parameter int NUM_LC = 2,
    localparam int SEL_W = (NUM_LC > 1) ? $clog2(NUM_LC) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rpt_req,
    input logic [1:0]              rpt_src,
    input logic [SIMM_W-1:0]       rpt_imm,
    input logic [CNT_W-1:0]        rpt_reg,
    input logic [CNT_W-1:0]        rpt_mem,
    input logic                    lc_ld,
    input logic [SEL_W-1:0]        lc_sel,
    input logic [SIMM_W-1:0]       lc_imm,
    input logic                    cr_wr,
    input logic [SEL_W-1:0]        cr_sel,
    input logic [CNT_W-1:0]        cr_wdata,
    input logic                    rep_exec,
    input logic                    pc_hold,
    input logic                    rep_done,
    input logic [NUM_LC*CNT_W-1:0] lc_vals
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rep_exec && rpt_req) |=> rep_exec);

    assert_hold_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> rep_exec);

    assert_hold_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (rep_exec && !rep_done));

    assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rep_done |=> !rep_exec);

    assert_end_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rep_exec) |-> $past(rep_done));

    assert_lc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_ld && lc_sel == '0) |=> (lc_vals[CNT_W-1:0] == CNT_W'($past(lc_imm))));

    assert_cr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_sel == '0 && !(lc_ld && lc_sel == '0))
        |=> (lc_vals[CNT_W-1:0] == $past(cr_wdata)));
endmodule

bind rep_loop_unit rl_checker #(.CNT_W(CNT_W), .SIMM_W(SIMM_W), .NUM_LC(NUM_LC)) u_chk (.*);

// File: tb/rep_loop_unit_bench.sv
`timescale 1ns/1ps
module rep_loop_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_req = 1'b0;
    logic [1:0]  rpt_src = 2'd0;
    logic [7:0]  rpt_imm = 8'd0;
    logic [15:0] rpt_reg = 16'd0;
    logic [15:0] rpt_mem = 16'd0;
    logic        lc_ld = 1'b0;
    logic [0:0]  lc_sel = 1'b0;
    logic [7:0]  lc_imm = 8'd0;
    logic        cr_wr = 1'b0;
    logic [0:0]  cr_sel = 1'b0;
    logic [15:0] cr_wdata = 16'd0;
    logic        rep_exec, pc_hold, rep_done;
    logic [31:0] lc_vals;

    int total = 0;
    int bad = 0;

    logic        m_act = 1'b0;
    logic [15:0] m_cnt = 16'd0;
    logic [15:0] m_lc [2] = '{16'd0, 16'd0};

    always #2.5 clk = ~clk;

    rep_loop_unit u_rep_loop_unit (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] src_count(input logic [1:0] s, input logic [7:0] i,
                                              input logic [15:0] r, input logic [15:0] m);
        if (s == 2'd1) return r;
        if (s == 2'd2) return m;
        return {8'd0, i};
    endfunction

    task automatic clear_inputs();
        rpt_req = 0; lc_ld = 0; cr_wr = 0;
    endtask

    // One clock: model the next state from the driven inputs, advance, compare at the falling edge.
    task automatic tick();
        logic        n_act;
        logic [15:0] n_cnt;
        logic [15:0] n_lc [2];
        n_act = m_act; n_cnt = m_cnt; n_lc = m_lc;
        if (!m_act) begin
            if (rpt_req) begin n_act = 1; n_cnt = src_count(rpt_src, rpt_imm, rpt_reg, rpt_mem); end
        end else if (m_cnt == 0) n_act = 0;
        else n_cnt = m_cnt - 1;
        if (cr_wr) n_lc[cr_sel] = cr_wdata;
        if (lc_ld) n_lc[lc_sel] = {8'd0, lc_imm};
        @(posedge clk);
        m_act = n_act; m_cnt = n_cnt; m_lc = n_lc;
        @(negedge clk);
        check(rep_exec == m_act, "R2 rep_exec", rep_exec, m_act);
        check(pc_hold == (m_act && m_cnt != 0), "R4 pc_hold", pc_hold, m_act && m_cnt != 0);
        check(rep_done == (m_act && m_cnt == 0), "R5 rep_done", rep_done, m_act && m_cnt == 0);
        check(lc_vals[15:0] == m_lc[0], "R8/R9 counter0", lc_vals[15:0], m_lc[0]);
        check(lc_vals[31:16] == m_lc[1], "R8/R9 counter1", lc_vals[31:16], m_lc[1]);
    endtask

    // Issue a request, then count execution cycles until idle.
    task automatic run_rep(input logic [1:0] s, input logic [7:0] i, input logic [15:0] r,
                           input logic [15:0] m, output int n);
        rpt_req = 1; rpt_src = s; rpt_imm = i; rpt_reg = r; rpt_mem = m;
        tick();
        clear_inputs();
        n = 0;
        while (rep_exec && n < 70000) begin n++; tick(); end
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rep_exec && !pc_hold && !rep_done, "R1 flags", {rep_exec, pc_hold, rep_done}, 0);
        check(lc_vals == 32'd0, "R1 counters", lc_vals, 0);
        rst_n = 1;
        tick();

        // R6: count zero
        rpt_req = 1; rpt_src = 2'd0; rpt_imm = 8'd0;
        tick(); clear_inputs();
        check(rep_done && !pc_hold && rep_exec, "R6 zero count", {rep_exec, pc_hold, rep_done}, 3'b101);
        tick();
        check(!rep_exec, "R6 one cycle only", rep_exec, 0);

        // R3: each source, with distracting values on the others
        run_rep(2'd0, 8'd4, 16'd30, 16'd40, n);
        check(n == 5, "R3 immediate source", n, 5);
        run_rep(2'd1, 8'd4, 16'd9, 16'd40, n);
        check(n == 10, "R3 register source", n, 10);
        run_rep(2'd2, 8'd4, 16'd9, 16'd2, n);
        check(n == 3, "R3 memory source", n, 3);
        run_rep(2'd3, 8'd6, 16'd9, 16'd2, n);
        check(n == 7, "R3 code 3 as immediate", n, 7);
        run_rep(2'd0, 8'hFF, 16'd0, 16'd0, n);
        check(n == 256, "R3 largest immediate", n, 256);
        run_rep(2'd1, 8'd0, 16'h0103, 16'd0, n);
        check(n == 260, "R3 wide register count", n, 260);

        // R7: requests during an active run and in its final cycle are dropped
        rpt_req = 1; rpt_src = 2'd0; rpt_imm = 8'd5;
        tick();
        rpt_imm = 8'd0; rpt_src = 2'd1; rpt_reg = 16'd50;
        n = 1;
        while (!rep_done && n < 100) begin tick(); n++; end
        tick();
        clear_inputs();
        check(n == 6, "R7 run length unchanged", n, 6);
        check(!rep_exec, "R7 final-cycle request dropped", rep_exec, 0);
        tick();

        // R10: same-counter collision and split targets
        lc_ld = 1; lc_sel = 1'b0; lc_imm = 8'hA5; cr_wr = 1; cr_sel = 1'b0; cr_wdata = 16'hBEEF;
        tick(); clear_inputs();
        check(lc_vals[15:0] == 16'h00A5, "R10 lc_ld wins", lc_vals[15:0], 16'h00A5);
        lc_ld = 1; lc_sel = 1'b1; lc_imm = 8'h3C; cr_wr = 1; cr_sel = 1'b0; cr_wdata = 16'hFFFF;
        tick(); clear_inputs();
        check(lc_vals == 32'h003C_FFFF, "R10 both writes", lc_vals, 32'h003C_FFFF);
        // R8: zero-extension over a full word
        lc_ld = 1; lc_sel = 1'b0; lc_imm = 8'h81;
        tick(); clear_inputs();
        check(lc_vals[15:0] == 16'h0081, "R8 zero-extended load", lc_vals[15:0], 16'h0081);
        // R9: full-word write
        cr_wr = 1; cr_sel = 1'b1; cr_wdata = 16'h1234;
        tick(); clear_inputs();
        check(lc_vals[31:16] == 16'h1234, "R9 full write", lc_vals[31:16], 16'h1234);

        // Random phase against the model
        void'($urandom(32'd1357));
        for (int k = 0; k < 4000; k++) begin
            rpt_req  = ($urandom % 4) == 0;
            rpt_src  = 2'($urandom);
            rpt_imm  = 8'($urandom % 48);
            rpt_reg  = 16'($urandom % 24);
            rpt_mem  = 16'($urandom % 24);
            lc_ld    = ($urandom % 6) == 0;
            lc_sel   = 1'($urandom);
            lc_imm   = 8'($urandom);
            cr_wr    = ($urandom % 6) == 0;
            cr_sel   = 1'($urandom);
            cr_wdata = 16'($urandom);
            tick();
        end
        clear_inputs();
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule